// File: doc/BRIEF.md
# IPv4 and TCP/UDP Header Sanity Checker

This block watches a received packet presented one byte per valid beat, starting at the first byte of the network-layer header and marked on its final byte by a last flag. While the bytes stream past it captures the header fields it needs and folds the IPv4 header into a running ones-complement sum. When the packet ends it classifies the packet into one network-layer exception code and one transport-layer error code. A done strobe then marks both codes as valid.

Each condition maps to one fixed number. Version errors, checksum failures, truncation, a zero TTL and the presence of IPv4 options are reported on the 3-bit network code. Truncated transport headers, UDP length disagreement, zero ports and illegal TCP flag sets are reported on the 4-bit transport code. A downstream stage uses the codes to drop or divert packets. IPv6 support is limited to version detection, a fixed-header length check and a hop-limit check. The transport payload checksum is not computed.

Top module: `ip_l4_sanity`

## Requirements
- R1: `done` is high for exactly one cycle, two clock edges after the edge that accepts a beat with `in_last` set. `ip_code` and `l4_code` change only on the edge that raises `done`, and they hold their values until the next `done`, even while the next packet streams in without a gap.
- R2: The network code is 1 when the version nibble (the high four bits of byte 0) is neither 4 nor 6. In that case the transport code is 0.
- R3: For version 4, the network code is 3 when the header length nibble (the low four bits of byte 0, counting 32-bit words) is below 5, or when fewer than IHL×4 bytes arrived. When the whole header arrived, the code is 2 if the ones-complement sum of its 16-bit big-endian words is not 0xFFFF. Code 3 takes precedence over code 2.
- R4: For version 4, with a complete and valid header, the network code is 4 when fewer bytes arrived than the total length in bytes 2–3. Bytes beyond the total length are accepted without error.
- R5: The network code is 5 when the IPv4 TTL (byte 8) is zero, or when the IPv6 hop limit (byte 7) is zero. An IPv6 packet shorter than 40 bytes gives code 3 instead.
- R6: The network code is 6 when IHL is greater than 5 and no lower-numbered network condition holds. This is the lowest-priority network code.
- R7: Transport checks run only for version 4 when the network code is 0, 5 or 6, the protocol (byte 9) is 6 or 17, the more-fragments flag (bit 5 of byte 6) is clear and the 13-bit fragment offset (byte 6 bits 4..0, then byte 7) is zero. Otherwise the transport code is 0.
- R8: The transport code is 1 when the payload length (total length minus IHL×4) is below 20 for TCP or below 8 for UDP.
- R9: For UDP, the transport code is 3 when the UDP length field (transport bytes 4–5) differs from the payload length.
- R10: The transport code is 4 when the source port (transport bytes 0–1) or the destination port (transport bytes 2–3) is zero.
- R11: For TCP, the flag byte at transport offset 13 (bit 0 FIN, bit 1 SYN, bit 2 RST, bit 5 URG) selects the transport code. The byte equal to 0x01 gives 8. The byte equal to 0x00 gives 9. FIN and RST together give 10. SYN and URG together give 11. SYN and RST together give 12. SYN and FIN together give 13. Where several apply, the lowest code wins. Any other flag byte gives 0.
- R12: Transport precedence is 1, then 3, then 4, then the flag codes.
- R13: Synchronous active-low reset clears `done` and both codes to 0. It also abandons any packet in progress, so the next accepted byte is byte 0 of a new packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A packet byte is present this cycle |
| in_byte | input | 8 | Packet byte, starting at the network header |
| in_last | input | 1 | This beat carries the final byte of the packet |
| ip_code | output | 3 | Network-layer exception code |
| l4_code | output | 4 | Transport-layer error code |
| done | output | 1 | One-cycle strobe: both codes are valid |

## Verification
The bench targets the places where conditions overlap:
- Truncation against the checksum: a design that checks the checksum over a partial header would report 2 instead of 3.
- A zero TTL against an options header, and a bad checksum against a zero TTL, which catch a wrong network priority order.
- Zero ports, fragments and non-TCP/UDP protocols together: a transport stage that ignores the gating would raise code 4 on packets it must not inspect.
- Every TCP flag combination, including overlaps such as SYN+FIN+RST. A wrong flag priority would give 13 where 10 is expected.
- Packets sent back to back with no idle cycle, where outputs that move early would show the second packet's codes before its strobe.
- Padded packets and one-byte packets, which catch length counters that are off by one.

// File: rtl/pkt_hdr_pkg.sv
// Shared constants, field view and code encodings for the header sanity checker.
// Assumes big-endian network byte order and one byte per accepted beat.
package pkt_hdr_pkg;

    localparam int LEN_W          = 16;  // width of byte counts and length fields
    localparam int NIB_W          = 4;
    localparam int MIN_IHL        = 5;
    localparam int V6_FIXED_BYTES = 40;
    localparam int TCP_HDR_BYTES  = 20;
    localparam int UDP_HDR_BYTES  = 8;
    localparam int PROTO_TCP      = 6;
    localparam int PROTO_UDP      = 17;
    localparam int TCP_FLAG_OFS   = 13;

    typedef enum logic [2:0] {
        IPX_NONE      = 3'd0,
        IPX_VERSION   = 3'd1,
        IPX_CSUM      = 3'd2,
        IPX_HDR_SHORT = 3'd3,
        IPX_PKT_SHORT = 3'd4,
        IPX_TTL       = 3'd5,
        IPX_OPTS      = 3'd6
    } ip_exc_e;

    typedef enum logic [3:0] {
        L4X_NONE     = 4'd0,
        L4X_SHORT    = 4'd1,
        L4X_LEN      = 4'd3,
        L4X_PORT     = 4'd4,
        L4X_FIN_ONLY = 4'd8,
        L4X_NO_FLAGS = 4'd9,
        L4X_FIN_RST  = 4'd10,
        L4X_SYN_URG  = 4'd11,
        L4X_SYN_RST  = 4'd12,
        L4X_SYN_FIN  = 4'd13
    } l4_err_e;

    // Fields gathered from one packet, plus the number of bytes seen.
    typedef struct packed {
        logic [NIB_W-1:0] ver;
        logic [NIB_W-1:0] ihl;
        logic [LEN_W-1:0] tot_len;
        logic             more_frags;
        logic [12:0]      frag_off;
        logic [7:0]       ttl;
        logic [7:0]       hop;
        logic [7:0]       proto;
        logic [15:0]      src_port;
        logic [15:0]      dst_port;
        logic [15:0]      udp_len;
        logic [7:0]       tcp_flags;
        logic [LEN_W-1:0] nbytes;
    } hdr_view_t;

endpackage

// File: rtl/hdr_field_capture.sv
// Tracks the byte position within the current packet and latches the header
// fields the checks need. Assumes the stream starts at byte 0 of the network
// header; the first valid beat after reset or after a last beat is byte 0.
// The byte count saturates at its maximum value.
module hdr_field_capture
    import pkt_hdr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             in_last,
    output hdr_view_t        view,
    output logic [LEN_W-1:0] cur_pos,
    output logic             pkt_start
);
    localparam logic [LEN_W-1:0] POS_MAX = '1;

    logic             in_pkt;
    hdr_view_t        view_nxt;
    logic [LEN_W-1:0] hdr_len;
    logic [LEN_W-1:0] l4_off;
    logic             l4_zone;

    assign pkt_start = !in_pkt;
    assign cur_pos   = in_pkt ? view.nbytes : '0;
    assign hdr_len   = LEN_W'({view.ihl, 2'b00});
    assign l4_off    = cur_pos - hdr_len;
    assign l4_zone   = in_pkt && (view.ihl >= NIB_W'(MIN_IHL)) && (cur_pos >= hdr_len);

    // Merge the current byte into the field view at its header position.
    always_comb begin
        view_nxt        = pkt_start ? '0 : view;
        view_nxt.nbytes = (cur_pos == POS_MAX) ? POS_MAX : cur_pos + 1'b1;
        case (cur_pos)
            LEN_W'(0): begin
                view_nxt.ver = in_byte[7:4];
                view_nxt.ihl = in_byte[3:0];
            end
            LEN_W'(2): view_nxt.tot_len[15:8] = in_byte;
            LEN_W'(3): view_nxt.tot_len[7:0]  = in_byte;
            LEN_W'(6): begin
                view_nxt.more_frags      = in_byte[5];
                view_nxt.frag_off[12:8]  = in_byte[4:0];
            end
            LEN_W'(7): begin
                view_nxt.frag_off[7:0] = in_byte;
                view_nxt.hop           = in_byte;
            end
            LEN_W'(8): view_nxt.ttl   = in_byte;
            LEN_W'(9): view_nxt.proto = in_byte;
            default: ;
        endcase
        if (l4_zone) begin
            case (l4_off)
                LEN_W'(0): view_nxt.src_port[15:8] = in_byte;
                LEN_W'(1): view_nxt.src_port[7:0]  = in_byte;
                LEN_W'(2): view_nxt.dst_port[15:8] = in_byte;
                LEN_W'(3): view_nxt.dst_port[7:0]  = in_byte;
                LEN_W'(4): view_nxt.udp_len[15:8]  = in_byte;
                LEN_W'(5): view_nxt.udp_len[7:0]   = in_byte;
                LEN_W'(TCP_FLAG_OFS): view_nxt.tcp_flags = in_byte;
                default: ;
            endcase
        end
    end

    // Advance the packet state on every accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt <= 1'b0;
            view   <= '0;
        end else if (in_valid) begin
            in_pkt <= !in_last;
            view   <= view_nxt;
        end
    end

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !pkt_start && view.nbytes != POS_MAX)
        |=> view.nbytes == $past(view.nbytes) + 1'b1);

endmodule

// File: rtl/ones_sum_acc.sv
// Running ones-complement sum of 16-bit words built from a byte stream.
// A byte is added to the high or the low lane; the carry wraps around.
// Assumes the first byte of each sum is loaded into the high lane.
module ones_sum_acc #(
    parameter int SUM_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             add,
    input  logic             hi_lane,
    input  logic [BYTE_W-1:0] data,
    output logic [SUM_W-1:0] sum
);
    localparam int PAD_W = SUM_W - BYTE_W;

    logic [SUM_W-1:0] addend;
    logic [SUM_W:0]   raw;
    logic [SUM_W-1:0] folded;

    assign addend = hi_lane ? {data, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, data};
    assign raw    = {1'b0, sum} + {1'b0, addend};
    assign folded = raw[SUM_W-1:0] + SUM_W'(raw[SUM_W]);

    // Start a new sum or fold in one more byte.
    always_ff @(posedge clk) begin
        if (!rst_n)    sum <= '0;
        else if (load) sum <= addend;
        else if (add)  sum <= folded;
    end

    // R3
    sum_keeps_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add && !load && sum != '0) |=> sum != '0);

endmodule

// File: rtl/exc_resolver.sv
// Combinational classification of a captured packet into one network-layer
// code and one transport-layer code, each by fixed priority.
// Assumes the view is complete, i.e. the last byte has been captured.
module exc_resolver
    import pkt_hdr_pkg::*;
(
    input  hdr_view_t  view,
    input  logic       csum_ok,
    output logic [2:0] ip_code,
    output logic [3:0] l4_code
);
    logic [LEN_W-1:0] hdr_len;
    logic [LEN_W:0]   need_len;
    logic [LEN_W-1:0] payload;
    logic             is_v4;
    logic             is_v6;
    logic             is_tcp;
    logic             is_udp;
    logic             l4_run;
    logic [7:0]       fl;

    assign hdr_len  = LEN_W'({view.ihl, 2'b00});
    assign is_v4    = view.ver == NIB_W'(4);
    assign is_v6    = view.ver == NIB_W'(6);
    assign is_tcp   = view.proto == 8'(PROTO_TCP);
    assign is_udp   = view.proto == 8'(PROTO_UDP);
    assign need_len = {1'b0, hdr_len} +
                      (is_tcp ? (LEN_W+1)'(TCP_HDR_BYTES) : (LEN_W+1)'(UDP_HDR_BYTES));
    assign payload  = view.tot_len - hdr_len;
    assign fl       = view.tcp_flags;

    // Network-layer code, lowest valid priority first.
    always_comb begin
        ip_code = IPX_NONE;
        if (!is_v4 && !is_v6)
            ip_code = IPX_VERSION;
        else if (is_v6) begin
            if (view.nbytes < LEN_W'(V6_FIXED_BYTES)) ip_code = IPX_HDR_SHORT;
            else if (view.hop == 8'd0)                ip_code = IPX_TTL;
        end else begin
            if (view.ihl < NIB_W'(MIN_IHL) || view.nbytes < hdr_len) ip_code = IPX_HDR_SHORT;
            else if (!csum_ok)                                      ip_code = IPX_CSUM;
            else if (view.nbytes < view.tot_len)                    ip_code = IPX_PKT_SHORT;
            else if (view.ttl == 8'd0)                              ip_code = IPX_TTL;
            else if (view.ihl > NIB_W'(MIN_IHL))                    ip_code = IPX_OPTS;
        end
    end

    assign l4_run = is_v4 && (ip_code == IPX_NONE || ip_code == IPX_TTL || ip_code == IPX_OPTS)
                    && (is_tcp || is_udp) && !view.more_frags && view.frag_off == '0;

    // Transport-layer code: malformation, length, ports, then TCP flags.
    always_comb begin
        l4_code = L4X_NONE;
        if (l4_run) begin
            if ({1'b0, view.tot_len} < need_len)                 l4_code = L4X_SHORT;
            else if (is_udp && view.udp_len != payload)          l4_code = L4X_LEN;
            else if (view.src_port == '0 || view.dst_port == '0) l4_code = L4X_PORT;
            else if (is_tcp) begin
                if (fl == 8'h01)              l4_code = L4X_FIN_ONLY;
                else if (fl == 8'h00)         l4_code = L4X_NO_FLAGS;
                else if (fl[0] && fl[2])      l4_code = L4X_FIN_RST;
                else if (fl[1] && fl[5])      l4_code = L4X_SYN_URG;
                else if (fl[1] && fl[2])      l4_code = L4X_SYN_RST;
                else if (fl[1] && fl[0])      l4_code = L4X_SYN_FIN;
            end
        end
    end

endmodule

// File: rtl/ip_l4_sanity.sv
// Top of the header sanity checker: captures fields, sums the IPv4 header,
// then one cycle after the last byte registers both codes and pulses done.
// Assumes the upstream never sends a byte before byte 0 of a packet.
module ip_l4_sanity
    import pkt_hdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       in_last,
    output logic [2:0] ip_code,
    output logic [3:0] l4_code,
    output logic       done
);
    localparam logic [15:0] SUM_GOOD = 16'hFFFF;

    hdr_view_t        view;
    logic [LEN_W-1:0] cur_pos;
    logic             pkt_start;
    logic [15:0]      hdr_sum;
    logic             sum_add;
    logic             eval_q;
    logic [2:0]       ip_c;
    logic [3:0]       l4_c;

    hdr_field_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .in_last   (in_last),
        .view      (view),
        .cur_pos   (cur_pos),
        .pkt_start (pkt_start)
    );

    assign sum_add = in_valid && !pkt_start && (cur_pos < LEN_W'({view.ihl, 2'b00}));

    ones_sum_acc #(.SUM_W(16), .BYTE_W(8)) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_valid && pkt_start),
        .add     (sum_add),
        .hi_lane (!cur_pos[0]),
        .data    (in_byte),
        .sum     (hdr_sum)
    );

    exc_resolver u_res (
        .view    (view),
        .csum_ok (hdr_sum == SUM_GOOD),
        .ip_code (ip_c),
        .l4_code (l4_c)
    );

    // Evaluate one cycle after the last byte, then hold until the next packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eval_q  <= 1'b0;
            done    <= 1'b0;
            ip_code <= '0;
            l4_code <= '0;
        end else begin
            eval_q <= in_valid && in_last;
            done   <= eval_q;
            if (eval_q) begin
                ip_code <= ip_c;
                l4_code <= l4_c;
            end
        end
    end

    // R1
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> ##1 done);

    // R1
    codes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(ip_code) && $stable(l4_code)));

    // R7
    l4_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ip_code >= 3'd1 && ip_code <= 3'd4) |-> l4_code == 4'd0);

    // R11
    l4_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (l4_code inside {4'd0, 4'd1, 4'd3, 4'd4, [4'd8:4'd13]}));

    // R6
    ip_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ip_code <= 3'd6);

endmodule

// File: tb/ip_l4_sanity_test.sv
`timescale 1ns/1ps
module ip_l4_sanity_test;

    typedef struct packed {
        logic [3:0]  req;
        logic [3:0]  ver;
        logic [3:0]  ihl;
        logic [15:0] tot;
        logic        mf;
        logic [12:0] foff;
        logic [7:0]  ttl;
        logic [7:0]  proto;
        logic [15:0] sp;
        logic [15:0] dp;
        logic [15:0] ulen;
        logic [7:0]  tfl;
        logic [7:0]  nb;
        logic        bad;
        logic [2:0]  eip;
        logic [3:0]  el4;
    } vec_t;

    function automatic vec_t mk(int req, int ver, int ihl, int tot, int mf, int foff,
                                int ttl, int proto, int sp, int dp, int ulen, int tfl,
                                int nb, int bad, int eip, int el4);
        vec_t v;
        v.req = 4'(req);   v.ver = 4'(ver);     v.ihl = 4'(ihl);   v.tot = 16'(tot);
        v.mf = 1'(mf);     v.foff = 13'(foff);  v.ttl = 8'(ttl);   v.proto = 8'(proto);
        v.sp = 16'(sp);    v.dp = 16'(dp);      v.ulen = 16'(ulen); v.tfl = 8'(tfl);
        v.nb = 8'(nb);     v.bad = 1'(bad);     v.eip = 3'(eip);   v.el4 = 4'(el4);
        return v;
    endfunction

    localparam int NV = 40;
    // req, ver, ihl, tot, mf, foff, ttl, proto, sport, dport, ulen, flags, bytes, badsum, exp ip, exp l4
    localparam vec_t TBL [NV] = '{
        mk( 8, 4, 5, 28, 0, 0, 64, 17, 1000, 53,  8, 8'h00, 28, 0, 0,  0), // R8 clean UDP
        mk(11, 4, 5, 40, 0, 0, 64,  6, 1000, 80,  0, 8'h10, 40, 0, 0,  0), // R11 clean TCP
        mk( 2, 5, 5, 28, 0, 0, 64, 17, 1000, 53,  8, 8'h00, 28, 0, 1,  0), // R2 version 5
        mk( 2, 0, 5, 20, 0, 0, 64, 17, 1000, 53,  8, 8'h00, 20, 0, 1,  0), // R2 version 0
        mk( 3, 4, 5, 28, 0, 0, 64, 17, 1000, 53,  8, 8'h00, 28, 1, 2,  0), // R3 bad sum
        mk( 3, 4, 5, 28, 0, 0, 64, 17, 1000, 53,  8, 8'h00, 12, 0, 3,  0), // R3 header cut
        mk( 3, 4, 4, 28, 0, 0, 64, 17, 1000, 53,  8, 8'h00, 28, 0, 3,  0), // R3 IHL 4
        mk( 3, 4, 5, 28, 0, 0, 64, 17, 1000, 53,  8, 8'h00,  1, 0, 3,  0), // R3 one byte
        mk( 4, 4, 5, 28, 0, 0, 64, 17, 1000, 53,  8, 8'h00, 24, 0, 4,  0), // R4 body cut
        mk( 4, 4, 5, 28, 0, 0, 64, 17, 1000, 53,  8, 8'h00, 34, 0, 0,  0), // R4 padding ok
        mk( 5, 4, 5, 28, 0, 0,  0, 17, 1000, 53,  8, 8'h00, 28, 0, 5,  0), // R5 TTL 0
        mk( 5, 4, 5, 28, 0, 0,  0, 17,    0, 53,  8, 8'h00, 28, 0, 5,  4), // R5 TTL 0, port 0
        mk( 5, 6, 0,  0, 0, 0,  0,  0,    0,  0,  0, 8'h00, 40, 0, 5,  0), // R5 v6 hop 0
        mk( 5, 6, 0,  0, 0, 0, 64,  0,    0,  0,  0, 8'h00, 40, 0, 0,  0), // R5 v6 clean
        mk( 5, 6, 0,  0, 0, 0, 64,  0,    0,  0,  0, 8'h00, 30, 0, 3,  0), // R5 v6 short
        mk( 6, 4, 6, 32, 0, 0, 64, 17, 1000, 53,  8, 8'h00, 32, 0, 6,  0), // R6 options
        mk( 6, 4, 6, 32, 0, 0,  0, 17, 1000, 53,  8, 8'h00, 32, 0, 5,  0), // R6 TTL beats options
        mk( 7, 4, 5, 28, 0, 0, 64,  1,    0,  0,  0, 8'h00, 28, 0, 0,  0), // R7 other protocol
        mk( 7, 4, 5, 28, 1, 0, 64, 17,    0, 53,  8, 8'h00, 28, 0, 0,  0), // R7 MF set
        mk( 7, 4, 5, 28, 0, 1, 64, 17,    0, 53,  8, 8'h00, 28, 0, 0,  0), // R7 offset set
        mk( 7, 4, 5, 28, 0, 0, 64, 17,    0, 53,  8, 8'h00, 28, 1, 2,  0), // R7 skip on bad sum
        mk( 8, 4, 5, 27, 0, 0, 64, 17, 1000, 53,  7, 8'h00, 27, 0, 0,  1), // R8 UDP short
        mk( 8, 4, 5, 39, 0, 0, 64,  6, 1000, 80,  0, 8'h10, 39, 0, 0,  1), // R8 TCP short
        mk( 9, 4, 5, 28, 0, 0, 64, 17, 1000, 53, 12, 8'h00, 28, 0, 0,  3), // R9 length mismatch
        mk(12, 4, 5, 28, 0, 0, 64, 17, 1000,  0, 12, 8'h00, 28, 0, 0,  3), // R12 length beats port
        mk(10, 4, 5, 28, 0, 0, 64, 17, 1000,  0,  8, 8'h00, 28, 0, 0,  4), // R10 dport 0
        mk(12, 4, 5, 40, 0, 0, 64,  6,    0, 80,  0, 8'h00, 40, 0, 0,  4), // R12 port beats flags
        mk(11, 4, 5, 40, 0, 0, 64,  6, 1000, 80,  0, 8'h01, 40, 0, 0,  8), // R11 FIN alone
        mk(11, 4, 5, 40, 0, 0, 64,  6, 1000, 80,  0, 8'h00, 40, 0, 0,  9), // R11 no flags
        mk(11, 4, 5, 40, 0, 0, 64,  6, 1000, 80,  0, 8'h05, 40, 0, 0, 10), // R11 FIN+RST
        mk(11, 4, 5, 40, 0, 0, 64,  6, 1000, 80,  0, 8'h22, 40, 0, 0, 11), // R11 SYN+URG
        mk(11, 4, 5, 40, 0, 0, 64,  6, 1000, 80,  0, 8'h06, 40, 0, 0, 12), // R11 SYN+RST
        mk(11, 4, 5, 40, 0, 0, 64,  6, 1000, 80,  0, 8'h03, 40, 0, 0, 13), // R11 SYN+FIN
        mk(11, 4, 5, 40, 0, 0, 64,  6, 1000, 80,  0, 8'h07, 40, 0, 0, 10), // R11 overlap
        mk(11, 4, 5, 40, 0, 0, 64,  6, 1000, 80,  0, 8'h02, 40, 0, 0,  0), // R11 SYN only
        mk(11, 4, 5, 40, 0, 0, 64,  6, 1000, 80,  0, 8'h11, 40, 0, 0,  0), // R11 FIN+ACK
        mk(12, 4, 5, 39, 0, 0, 64,  6, 1000, 80,  0, 8'h00, 39, 0, 0,  1), // R12 short beats flags
        mk( 3, 4, 5, 28, 0, 0,  0, 17, 1000, 53,  8, 8'h00, 28, 1, 2,  0), // R3 sum beats TTL
        mk( 7, 4, 5, 40, 0, 9, 64,  6, 1000, 80,  0, 8'h00, 40, 0, 0,  0), // R7 TCP fragment
        mk( 6, 4, 6, 44, 0, 0, 64,  6, 1000, 80,  0, 8'h03, 44, 0, 6, 13)  // R6 options with TCP
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [7:0] in_byte;
    logic       in_last;
    logic [2:0] ip_code;
    logic [3:0] l4_code;
    logic       done;

    logic [7:0] pkt  [64];
    logic [7:0] pktb [64];
    int         plen;
    int         nchk = 0;
    int         nfail = 0;

    always #2 clk = ~clk;

    ip_l4_sanity uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_last(in_last), .ip_code(ip_code), .l4_code(l4_code), .done(done)
    );

    task automatic chk(input int req, input string what, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nfail++;
            $display("FAIL R%0d %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Build the packet bytes for one vector into pkt.
    task automatic build(input vec_t v);
        int h;
        logic [16:0] t;
        logic [15:0] s;
        for (int i = 0; i < 64; i++) pkt[i] = 8'h00;
        plen = int'(v.nb);
        if (v.ver != 4'd4) begin
            pkt[0] = {v.ver, 4'h0};
            pkt[7] = v.ttl;
        end else begin
            h = int'(v.ihl) * 4;
            pkt[0] = {v.ver, v.ihl};
            pkt[2] = v.tot[15:8];  pkt[3] = v.tot[7:0];
            pkt[4] = 8'h12;        pkt[5] = 8'h34;
            pkt[6] = {2'b00, v.mf, v.foff[12:8]};
            pkt[7] = v.foff[7:0];
            pkt[8] = v.ttl;        pkt[9] = v.proto;
            pkt[12] = 8'hC0; pkt[13] = 8'hA8; pkt[14] = 8'h00; pkt[15] = 8'h01;
            pkt[16] = 8'h0A; pkt[17] = 8'h00; pkt[18] = 8'h00; pkt[19] = 8'h02;
            pkt[h]   = v.sp[15:8]; pkt[h+1] = v.sp[7:0];
            pkt[h+2] = v.dp[15:8]; pkt[h+3] = v.dp[7:0];
            if (v.proto == 8'd17) begin
                pkt[h+4] = v.ulen[15:8]; pkt[h+5] = v.ulen[7:0];
            end else if (v.proto == 8'd6) begin
                pkt[h+12] = 8'h50; pkt[h+13] = v.tfl;
            end
            s = 16'h0000;
            for (int k = 0; k < h / 2; k++) begin
                t = {1'b0, s} + {1'b0, pkt[2*k], pkt[2*k+1]};
                s = t[15:0] + {15'b0, t[16]};
            end
            s = ~s;
            if (v.bad) s = s ^ 16'h0001;
            pkt[10] = s[15:8]; pkt[11] = s[7:0];
        end
    endtask

    // Stream pkt, then check done and the codes at the strobe and after it.
    task automatic send_and_check(input int req, input int eip, input int el4);
        for (int i = 0; i < plen; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_byte = pkt[i]; in_last = (i == plen - 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        @(negedge clk);
        chk(req, "done strobe", int'(done), 1);
        chk(req, "ip code", int'(ip_code), eip);
        chk(req, "l4 code", int'(l4_code), el4);
        @(negedge clk);
        chk(1, "done single cycle", int'(done), 0); // R1
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00; in_last = 1'b0;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk(13, "reset done", int'(done), 0);
        chk(13, "reset ip", int'(ip_code), 0);
        chk(13, "reset l4", int'(l4_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(13, "idle done", int'(done), 0);

        for (int n = 0; n < NV; n++) begin
            build(TBL[n]);
            send_and_check(int'(TBL[n].req), int'(TBL[n].eip), int'(TBL[n].el4));
        end

        // R1: back-to-back packets, codes held until the second strobe
        build(TBL[10]);                       // TTL 0 -> 5/0
        for (int i = 0; i < 64; i++) pktb[i] = pkt[i];
        for (int i = 0; i < 28; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_byte = pktb[i]; in_last = (i == 27);
        end
        build(TBL[27]);                       // FIN alone -> 0/8
        for (int j = 0; j < plen; j++) begin
            @(negedge clk);
            if (j == 1) begin
                chk(1, "first strobe", int'(done), 1);
                chk(1, "first ip", int'(ip_code), 5);
                chk(1, "first l4", int'(l4_code), 0);
            end
            if (j == 3) begin
                chk(1, "no strobe mid packet", int'(done), 0);
                chk(1, "ip held", int'(ip_code), 5);
                chk(1, "l4 held", int'(l4_code), 0);
            end
            in_valid = 1'b1; in_byte = pkt[j]; in_last = (j == plen - 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        chk(1, "held before second strobe", int'(l4_code), 0);
        @(negedge clk);
        chk(1, "second strobe", int'(done), 1);
        chk(1, "second l4", int'(l4_code), 8);

        // R13: reset clears codes and abandons a partial packet
        build(TBL[5]);
        send_and_check(3, 3, 0);
        build(TBL[1]);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_byte = pkt[i]; in_last = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(13, "reset clears ip", int'(ip_code), 0);
        chk(13, "reset clears done", int'(done), 0);
        rst_n = 1'b1;
        build(TBL[27]);
        send_and_check(13, 0, 8);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule